// File: doc/BRIEF.md
# Byte-Order Conversion Unit

This unit turns a 64-bit register value into a requested byte order at a granularity of 16, 32 or 64 bits. The caller supplies the operand, a width code taken from an instruction immediate, a direction bit and an instruction-class bit. A synthesis-time parameter states whether the host is little-endian or big-endian.

In the narrow (32-bit) instruction class the bytes are reversed only when the requested order differs from the host order. In the wide (64-bit) instruction class the selected width is always reversed, whatever the host order and direction. For the 16 and 32-bit widths the bits above the width are cleared. A width code outside the three legal values raises an illegal-operation flag, and the operand then passes through unchanged.

The result is registered. It appears with a valid strobe one clock after the request. Full opcode decode, the register file and the other arithmetic functions belong to neighbouring blocks.

Top module: `byteorder_conv`

## Requirements
- R1: Only `width_imm` values 16, 32 and 64 are legal. Any other value gives `illegal_o` = 1 and `result_o` equal to the operand of that request.
- R2: `out_valid_o` rises on the clock edge after the edge at which `in_valid_i` was sampled high. `result_o` and `illegal_o` are updated on that same edge. `out_valid_o` is low after any edge at which `in_valid_i` was low.
- R3: With `wide_class_i` = 1, the lowest width/8 bytes of the operand are written in reverse order. Byte k of the result is byte (width/8 - 1 - k) of the operand. This holds for both values of `to_big_i` and for either host order.
- R4: With `wide_class_i` = 0 and a direction that differs from the host order, the low bytes are reversed as in R3. On a little-endian host this direction is `to_big_i` = 1, and on a big-endian host it is `to_big_i` = 0.
- R5: With `wide_class_i` = 0 and a direction that matches the host order, the low width/8 bytes keep their positions.
- R6: For widths 16 and 32, the result bits at and above the width are zero. This applies whether or not the bytes were reversed.
- R7: While reset is held, and until the first accepted request, `out_valid_o`, `illegal_o` and `result_o` are all zero.
- R8: After an edge at which `in_valid_i` is low, `result_o` and `illegal_o` keep their previous values.
- R9: A legal width code gives `illegal_o` = 0. The parameter `HOST_BIG_ENDIAN` defaults to 0, which means a little-endian host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| operand_i | input | 64 | Value to convert |
| width_imm_i | input | 32 | Width code from the immediate (16, 32 or 64) |
| to_big_i | input | 1 | 1 requests big-endian order, 0 requests little-endian order |
| wide_class_i | input | 1 | 1 selects the wide class, where the bytes are always reversed |
| out_valid_o | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 64 | Converted value |
| illegal_o | output | 1 | Width code was not legal |

## Verification
Every output of this block is due exactly one rising edge after the request: the valid strobe, the converted value and the illegal flag all arrive together. The bench drives each request on a falling edge and samples on the next falling edge. That point lies after the single register and before any later request can disturb it. Hold behaviour is checked by sampling again after further edges with the strobe low. For back-to-back requests, each result is compared on the falling edge that follows its own sampling edge.

// File: rtl/bo_pkg.sv
package bo_pkg;
  localparam int BO_WORD_W = 64;

  typedef enum logic [1:0] {
    WSEL_16  = 2'd0,
    WSEL_32  = 2'd1,
    WSEL_64  = 2'd2,
    WSEL_BAD = 2'd3
  } wsel_e;

  // Mask that keeps the bits below the selected width.
  function automatic logic [BO_WORD_W-1:0] width_mask(input wsel_e sel);
    logic [BO_WORD_W-1:0] m;
    case (sel)
      WSEL_16: m = {{(BO_WORD_W-16){1'b0}}, {16{1'b1}}};
      WSEL_32: m = {{(BO_WORD_W-32){1'b0}}, {32{1'b1}}};
      default: m = {BO_WORD_W{1'b1}};
    endcase
    return m;
  endfunction

  // Decide whether the bytes must be reversed.
  function automatic logic need_swap(input logic wide, input logic to_big,
                                     input logic host_big);
    return wide | (to_big ^ host_big);
  endfunction
endpackage

// File: rtl/bo_width_decode.sv
module bo_width_decode #(
  parameter int IMM_W = 32
) (
  input  logic [IMM_W-1:0] imm_i,
  output bo_pkg::wsel_e    sel_o,
  output logic             bad_o
);
  import bo_pkg::*;

  always_comb begin
    case (imm_i)
      IMM_W'(16): sel_o = WSEL_16;
      IMM_W'(32): sel_o = WSEL_32;
      IMM_W'(64): sel_o = WSEL_64;
      default:    sel_o = WSEL_BAD;
    endcase
  end

  assign bad_o = (sel_o == WSEL_BAD);
endmodule

// File: rtl/bo_byte_reverse.sv
module bo_byte_reverse #(
  parameter int DATA_W = 64,
  parameter int NGRAN  = 3
) (
  input  logic [DATA_W-1:0]            d_i,
  output logic [NGRAN-1:0][DATA_W-1:0] rev_o
);
  // Granularity g covers 2 << g bytes (2, 4, 8 bytes).
  for (genvar g = 0; g < NGRAN; g++) begin : g_gran
    localparam int NB = 2 << g;
    for (genvar i = 0; i < NB; i++) begin : g_byte
      assign rev_o[g][8*i +: 8] = d_i[8*(NB-1-i) +: 8];
    end
    if (NB * 8 < DATA_W) begin : g_upper
      assign rev_o[g][DATA_W-1:NB*8] = '0;
    end
  end
endmodule

// File: rtl/bo_swap_policy.sv
module bo_swap_policy #(
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic wide_i,
  input  logic to_big_i,
  output logic swap_o
);
  assign swap_o = bo_pkg::need_swap(wide_i, to_big_i, HOST_BIG_ENDIAN);
endmodule

// File: rtl/byteorder_conv.sv
module byteorder_conv #(
  parameter int DATA_W          = bo_pkg::BO_WORD_W,
  parameter int IMM_W           = 32,
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [IMM_W-1:0]  width_imm_i,
  input  logic              to_big_i,
  input  logic              wide_class_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  import bo_pkg::*;

  localparam int NGRAN = 3;

  wsel_e                     dec_sel;
  logic                      dec_bad;
  logic                      swap_req;
  logic [NGRAN-1:0][DATA_W-1:0] rev_all;
  logic [DATA_W-1:0]         rev_pick;
  logic [DATA_W-1:0]         keep_val;
  logic [DATA_W-1:0]         next_res;
  wsel_e                     q_sel;

  bo_width_decode #(.IMM_W(IMM_W)) u_dec (
    .imm_i (width_imm_i),
    .sel_o (dec_sel),
    .bad_o (dec_bad)
  );

  bo_swap_policy #(.HOST_BIG_ENDIAN(HOST_BIG_ENDIAN)) u_pol (
    .wide_i   (wide_class_i),
    .to_big_i (to_big_i),
    .swap_o   (swap_req)
  );

  bo_byte_reverse #(.DATA_W(DATA_W), .NGRAN(NGRAN)) u_rev (
    .d_i   (operand_i),
    .rev_o (rev_all)
  );

  always_comb begin
    case (dec_sel)
      WSEL_16: rev_pick = rev_all[0];
      WSEL_32: rev_pick = rev_all[1];
      default: rev_pick = rev_all[2];
    endcase
  end

  assign keep_val = operand_i & width_mask(dec_sel);

  always_comb begin
    if (dec_bad)       next_res = operand_i;
    else if (swap_req) next_res = rev_pick;
    else               next_res = keep_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      illegal_o   <= 1'b0;
      q_sel       <= WSEL_64;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o  <= next_res;
        illegal_o <= dec_bad;
        q_sel     <= dec_sel;
      end
    end
  end
endmodule

// File: rtl/byteorder_conv_chk.sv
module byteorder_conv_chk #(
  parameter int DATA_W          = 64,
  parameter int IMM_W           = 32,
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [IMM_W-1:0]  width_imm_i,
  input logic              to_big_i,
  input logic              wide_class_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o,
  input logic              dec_bad,
  input bo_pkg::wsel_e     q_sel
);
  import bo_pkg::*;

  logic legal_req;
  logic native_full;
  assign legal_req   = (width_imm_i == IMM_W'(16)) || (width_imm_i == IMM_W'(32)) ||
                       (width_imm_i == IMM_W'(64));
  assign native_full = !wide_class_i && (to_big_i == HOST_BIG_ENDIAN) &&
                       (width_imm_i == IMM_W'(64));

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o); // R2
  AST_BAD_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !legal_req) |=> (illegal_o && result_o == $past(operand_i))); // R1
  AST_LEGAL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && legal_req) |=> !illegal_o); // R9
  AST_NATIVE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && native_full) |=> (result_o == $past(operand_i))); // R5
  AST_UPPER16_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !illegal_o && q_sel == WSEL_16) |-> (result_o[DATA_W-1:16] == '0)); // R6
  AST_UPPER32_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !illegal_o && q_sel == WSEL_32) |-> (result_o[DATA_W-1:32] == '0)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(result_o) && $stable(illegal_o))); // R8
  AST_FLAG_MATCHES_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> (illegal_o == $past(dec_bad))); // R1
endmodule

bind byteorder_conv byteorder_conv_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .HOST_BIG_ENDIAN(HOST_BIG_ENDIAN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .operand_i(operand_i),
  .width_imm_i(width_imm_i), .to_big_i(to_big_i), .wide_class_i(wide_class_i),
  .out_valid_o(out_valid_o), .result_o(result_o), .illegal_o(illegal_o),
  .dec_bad(dec_bad), .q_sel(q_sel)
);

// File: tb/byteorder_conv_tb_top.sv
module byteorder_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] operand = '0;
  logic [31:0] width_imm = '0;
  logic        to_big = 1'b0;
  logic        wide = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  byteorder_conv dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .operand_i(operand),
    .width_imm_i(width_imm), .to_big_i(to_big), .wide_class_i(wide),
    .out_valid_o(out_valid), .result_o(result), .illegal_o(illegal)
  );

  // Expected value from the requirements; little-endian host (default).
  function automatic logic [63:0] model(input logic [63:0] v, input logic [31:0] w,
                                        input logic tb, input logic wd);
    logic [63:0] r = '0;
    int nb;
    bit rev;
    if (w != 16 && w != 32 && w != 64) return v;
    nb  = int'(w) / 8;
    rev = wd || tb;
    for (int k = 0; k < nb; k++)
      r[8*k +: 8] = rev ? v[8*(nb-1-k) +: 8] : v[8*k +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request, checked on the falling edge after the sampling edge.
  task automatic op(input string req, input logic [63:0] v, input logic [31:0] w,
                    input logic tb, input logic wd);
    @(negedge clk);
    operand = v; width_imm = w; to_big = tb; wide = wd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check({req, " result"}, result, model(v, w, tb, wd));
    check({req, " illegal"}, {63'd0, illegal},
          {63'd0, !(w == 16 || w == 32 || w == 64)});
  endtask

  task automatic t_reset;
    check("R7 valid", {63'd0, out_valid}, 64'd0);
    check("R7 result", result, 64'd0);
    check("R7 illegal", {63'd0, illegal}, 64'd0);
  endtask

  task automatic t_illegal;
    op("R1 imm0", 64'h0123_4567_89AB_CDEF, 32'd0, 1'b1, 1'b0);
    op("R1 imm8", 64'hDEAD_BEEF_0BAD_F00D, 32'd8, 1'b0, 1'b1);
    op("R1 imm48", 64'h1122_3344_5566_7788, 32'd48, 1'b1, 1'b1);
    op("R9 legal clears flag", 64'h1122_3344_5566_7788, 32'd64, 1'b0, 1'b0);
  endtask

  task automatic t_wide;
    op("R3 w16 le", 64'h0123_4567_89AB_CDEF, 32'd16, 1'b0, 1'b1);
    op("R3 w32 be", 64'h0123_4567_89AB_CDEF, 32'd32, 1'b1, 1'b1);
    op("R3 w64 le", 64'h0123_4567_89AB_CDEF, 32'd64, 1'b0, 1'b1);
    check("R3 literal", result, 64'hEFCD_AB89_6745_2301);
  endtask

  task automatic t_narrow_swap;
    op("R4 w16", 64'hFFFF_FFFF_FFFF_A1B2, 32'd16, 1'b1, 1'b0);
    check("R4 literal", result, 64'h0000_0000_0000_B2A1);
    op("R4 w64", 64'h8877_6655_4433_2211, 32'd64, 1'b1, 1'b0);
  endtask

  task automatic t_narrow_native;
    op("R5 w32", 64'hCAFE_F00D_1234_5678, 32'd32, 1'b0, 1'b0);
    check("R5 literal", result, 64'h0000_0000_1234_5678);
    op("R5 w64", 64'hCAFE_F00D_1234_5678, 32'd64, 1'b0, 1'b0);
  endtask

  task automatic t_upper_clear;
    op("R6 w16 native", 64'hFFFF_FFFF_FFFF_FFFF, 32'd16, 1'b0, 1'b0);
    check("R6 upper16", result >> 16, 64'd0);
    op("R6 w32 swap", 64'hFFFF_FFFF_FFFF_FFFF, 32'd32, 1'b0, 1'b1);
    check("R6 upper32", result >> 32, 64'd0);
  endtask

  task automatic t_hold;
    op("R8 setup", 64'h0F0E_0D0C_0B0A_0908, 32'd64, 1'b1, 1'b0);
    @(negedge clk);
    operand = 64'hFFFF_0000_FFFF_0000; width_imm = 32'd7;
    repeat (3) @(negedge clk);
    check("R8 result held", result, 64'h0809_0A0B_0C0D_0E0F);
    check("R8 illegal held", {63'd0, illegal}, 64'd0);
    check("R2 idle valid", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    operand = 64'h0000_0000_0000_AABB; width_imm = 32'd16; to_big = 1'b1; wide = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    check("R2 b2b first", result, 64'h0000_0000_0000_BBAA);
    operand = 64'h1111_2222_3333_4444; width_imm = 32'd5;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 b2b second", result, 64'h1111_2222_3333_4444);
    check("R2 b2b flag", {63'd0, illegal}, 64'd1);
    @(negedge clk);
    check("R2 drop valid", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_illegal();
    t_wide();
    t_narrow_swap();
    t_narrow_native();
    t_upper_clear();
    t_hold();
    t_back_to_back();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule